// File: doc/BRIEF.md
# Sequential Stream Buffer Prefetcher

This unit sits between a cache and the next memory level and handles the cache's misses. A miss address is compared against the oldest entry of each of several stream buffers. Each stream buffer is a small FIFO of consecutive block addresses, with the data fetched for them. If an oldest entry matches and its data has arrived, the block goes straight back to the cache and the entry is retired. The freed slot is then reused to prefetch the block after the last one that stream has queued. If nothing matches, the missed block is fetched from memory on demand. In the same cycle, the least recently used stream is wiped and refilled with the blocks that directly follow the missed one.

Prefetched blocks never enter the cache until they are demanded, and every stream walks its own address run independently. The unit does not care whether a miss comes from instruction fetch or from data access. Memory requests carry only a block address. Responses return that address with the data and may arrive in any order. Responses that no longer match a waiting entry are dropped.

Top module: `sbp_prefetch`

## Requirements
- R1: After synchronous reset, no block is returned to the cache, no memory request is raised, and the unit accepts a miss.
- R2: A miss whose address matches no stream's oldest entry issues a memory request for exactly that block address. It returns that block to the cache with the data memory answered, using the same address.
- R3: Such an unmatched miss at address A restarts a stream buffer so that it prefetches blocks A+1 through A+DEPTH. Every prefetch request carries a known address.
- R4: A miss that matches a stream's oldest entry whose data has arrived returns that block in the cycle after acceptance. It raises no memory request for that block.
- R5: Retiring an oldest entry issues a prefetch for the block after the last address that stream has queued (its last queued address plus one).
- R6: If the matching oldest entry is still waiting for memory, the miss is held (ready low) until the data arrives. No second request for that block is issued, and the block is then returned in the cycle after acceptance.
- R7: Only the oldest entry of each stream is compared. A miss equal to a younger queued address counts as unmatched.
- R8: The stream restarted on an unmatched miss is the least recently used one. Both a match and a restart count as a use. Streams used more recently keep their contents.
- R9: Streams advance independently: interleaved matches on different streams each retire and extend only their own stream.
- R10: Exactly one block return follows each accepted miss, in acceptance order. A new miss is never accepted while an earlier one is still unreturned, except in the cycle that return appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| miss_valid | input | 1 | Cache presents a miss |
| miss_addr | input | ADDR_W | Block address of the miss |
| miss_ready | output | 1 | Miss accepted at this edge when valid |
| ret_valid | output | 1 | One-cycle pulse: block returned to the cache |
| ret_addr | output | ADDR_W | Address of the returned block |
| ret_data | output | DATA_W | Data of the returned block |
| mem_req_valid | output | 1 | Memory read request |
| mem_req_addr | output | ADDR_W | Block address requested |
| mem_req_ready | input | 1 | Memory takes the request at this edge |
| mem_rsp_valid | input | 1 | Memory response present |
| mem_rsp_addr | input | ADDR_W | Block address of the response |
| mem_rsp_data | input | DATA_W | Block data of the response |

## Verification
The properties assume the following about the cache:
- It holds `miss_valid` and `miss_addr` steady until `miss_ready`.
- It never expects a return before one was earned.

They assume the following about memory:
- It answers each accepted request eventually.
- It answers with a known address.

The stimulus meets these assumptions. It changes inputs only on the falling clock edge, and it keeps a miss asserted until it is accepted. Its memory model answers every request with data that is a fixed function of the address. One chosen address is answered much later than the others, which makes the stall on a waiting oldest entry appear deterministically.

// File: rtl/sbp_pkg.sv
package sbp_pkg;

    // life cycle of one stream buffer slot
    typedef enum logic [1:0] {
        SLOT_REQ  = 2'd0,   // address queued, memory not yet asked
        SLOT_WAIT = 2'd1,   // request sent, data outstanding
        SLOT_FULL = 2'd2    // data present
    } slot_st_e;

    // demand path of the miss controller
    typedef enum logic [1:0] {
        CT_IDLE     = 2'd0,
        CT_DEM_REQ  = 2'd1,
        CT_DEM_WAIT = 2'd2
    } ctrl_st_e;

    function automatic int idx_bits(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/sbp_stream.sv
module sbp_stream
    import sbp_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    parameter int DEPTH  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              alloc,
    input  logic [ADDR_W-1:0] alloc_addr,
    input  logic              pop,
    input  logic              rsp_valid,
    input  logic [ADDR_W-1:0] rsp_addr,
    input  logic [DATA_W-1:0] rsp_data,
    input  logic              grant,
    output logic              head_live,
    output logic [ADDR_W-1:0] head_addr,
    output logic              head_full,
    output logic [DATA_W-1:0] head_data,
    output logic              req_valid,
    output logic [ADDR_W-1:0] req_addr
);
    localparam int PTR_W = idx_bits(DEPTH);

    logic [ADDR_W-1:0] addr_q [DEPTH];
    logic [DATA_W-1:0] data_q [DEPTH];
    slot_st_e          st_q   [DEPTH];
    logic [PTR_W-1:0]  head_q;
    logic [ADDR_W-1:0] last_q;
    logic              live_q;

    logic [PTR_W-1:0]  scan;
    logic [PTR_W-1:0]  req_slot;

    // oldest queued slot still needing a request, scanned in FIFO order
    always_comb begin
        req_valid = 1'b0;
        req_slot  = '0;
        scan      = '0;
        for (int k = DEPTH - 1; k >= 0; k--) begin
            scan = head_q + PTR_W'(k);
            if (live_q && st_q[scan] == SLOT_REQ) begin
                req_valid = 1'b1;
                req_slot  = scan;
            end
        end
        req_addr = addr_q[req_slot];
    end

    assign head_live = live_q;
    assign head_addr = addr_q[head_q];
    assign head_full = live_q && (st_q[head_q] == SLOT_FULL);
    assign head_data = data_q[head_q];

    always_ff @(posedge clk) begin
        if (rst) begin
            live_q <= 1'b0;
            head_q <= '0;
            last_q <= '0;
            for (int k = 0; k < DEPTH; k++) begin
                addr_q[k] <= '0;
                data_q[k] <= '0;
                st_q[k]   <= SLOT_REQ;
            end
        end else begin
            if (rsp_valid) begin
                for (int k = 0; k < DEPTH; k++) begin
                    if (st_q[k] == SLOT_WAIT && addr_q[k] == rsp_addr) begin
                        st_q[k]   <= SLOT_FULL;
                        data_q[k] <= rsp_data;
                    end
                end
            end
            if (grant) begin
                st_q[req_slot] <= SLOT_WAIT;
            end
            if (pop) begin
                addr_q[head_q] <= last_q + ADDR_W'(1);
                st_q[head_q]   <= SLOT_REQ;
                last_q         <= last_q + ADDR_W'(1);
                head_q         <= head_q + PTR_W'(1);
            end
            if (alloc) begin
                for (int k = 0; k < DEPTH; k++) begin
                    addr_q[k] <= alloc_addr + ADDR_W'(k + 1);
                    st_q[k]   <= SLOT_REQ;
                end
                head_q <= '0;
                last_q <= alloc_addr + ADDR_W'(DEPTH);
                live_q <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/sbp_lru.sv
module sbp_lru
    import sbp_pkg::*;
#(
    parameter int NUM = 4
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     touch,
    input  logic [idx_bits(NUM)-1:0] touch_idx,
    output logic [idx_bits(NUM)-1:0] victim
);
    localparam int IW = idx_bits(NUM);

    // rank 0 = most recent, NUM-1 = least recent
    logic [IW-1:0] rank_q [NUM];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM; i++) rank_q[i] <= IW'(NUM - 1 - i);
        end else if (touch) begin
            for (int i = 0; i < NUM; i++) begin
                if (IW'(i) == touch_idx)
                    rank_q[i] <= '0;
                else if (rank_q[i] < rank_q[touch_idx])
                    rank_q[i] <= rank_q[i] + IW'(1);
            end
        end
    end

    always_comb begin
        victim = '0;
        for (int i = NUM - 1; i >= 0; i--)
            if (rank_q[i] == IW'(NUM - 1)) victim = IW'(i);
    end
endmodule

// File: rtl/sbp_req_arb.sv
module sbp_req_arb #(
    parameter int ADDR_W = 16,
    parameter int NUM    = 4
) (
    input  logic              dem_valid,
    input  logic [ADDR_W-1:0] dem_addr,
    input  logic [NUM-1:0]    s_req_valid,
    input  logic [ADDR_W-1:0] s_req_addr [NUM],
    input  logic              mem_ready,
    output logic              mem_req_valid,
    output logic [ADDR_W-1:0] mem_req_addr,
    output logic              dem_grant,
    output logic [NUM-1:0]    s_grant
);
    // demand first, then lowest-numbered stream
    always_comb begin
        mem_req_valid = dem_valid;
        mem_req_addr  = dem_addr;
        dem_grant     = dem_valid && mem_ready;
        s_grant       = '0;
        if (!dem_valid) begin
            for (int i = NUM - 1; i >= 0; i--) begin
                if (s_req_valid[i]) begin
                    mem_req_valid = 1'b1;
                    mem_req_addr  = s_req_addr[i];
                    s_grant       = '0;
                    s_grant[i]    = mem_ready;
                end
            end
        end
    end
endmodule

// File: rtl/sbp_prefetch.sv
module sbp_prefetch
    import sbp_pkg::*;
#(
    parameter int ADDR_W      = 16,
    parameter int DATA_W      = 32,
    parameter int NUM_STREAMS = 4,
    parameter int DEPTH       = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              miss_valid,
    input  logic [ADDR_W-1:0] miss_addr,
    output logic              miss_ready,
    output logic              ret_valid,
    output logic [ADDR_W-1:0] ret_addr,
    output logic [DATA_W-1:0] ret_data,
    output logic              mem_req_valid,
    output logic [ADDR_W-1:0] mem_req_addr,
    input  logic              mem_req_ready,
    input  logic              mem_rsp_valid,
    input  logic [ADDR_W-1:0] mem_rsp_addr,
    input  logic [DATA_W-1:0] mem_rsp_data
);
    localparam int SIW = idx_bits(NUM_STREAMS);

    ctrl_st_e          state_q;
    logic [ADDR_W-1:0] dem_addr_q;

    logic [NUM_STREAMS-1:0] h_live, h_full, s_req_v, s_grant, hit_vec, pop_v, alloc_v;
    logic [ADDR_W-1:0]      h_addr [NUM_STREAMS];
    logic [DATA_W-1:0]      h_data [NUM_STREAMS];
    logic [ADDR_W-1:0]      s_req_a [NUM_STREAMS];
    logic [SIW-1:0]         hit_idx, victim, touch_idx;
    logic                   any_hit, accept, dem_grant, dem_done;

    always_comb begin
        hit_idx = '0;
        for (int i = NUM_STREAMS - 1; i >= 0; i--) begin
            hit_vec[i] = h_live[i] && (h_addr[i] == miss_addr);
            if (hit_vec[i]) hit_idx = SIW'(i);
        end
    end

    assign any_hit    = |hit_vec;
    assign miss_ready = (state_q == CT_IDLE) && (!any_hit || h_full[hit_idx]);
    assign accept     = miss_valid && miss_ready;
    assign touch_idx  = any_hit ? hit_idx : victim;
    assign dem_done   = (state_q == CT_DEM_WAIT) && mem_rsp_valid && (mem_rsp_addr == dem_addr_q);

    always_comb begin
        for (int i = 0; i < NUM_STREAMS; i++) begin
            pop_v[i]   = accept && any_hit && (hit_idx == SIW'(i));
            alloc_v[i] = accept && !any_hit && (victim == SIW'(i));
        end
    end

    for (genvar g = 0; g < NUM_STREAMS; g++) begin : g_stream
        sbp_stream #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH)) u_stream (
            .clk(clk), .rst(rst),
            .alloc(alloc_v[g]), .alloc_addr(miss_addr), .pop(pop_v[g]),
            .rsp_valid(mem_rsp_valid), .rsp_addr(mem_rsp_addr), .rsp_data(mem_rsp_data),
            .grant(s_grant[g]),
            .head_live(h_live[g]), .head_addr(h_addr[g]), .head_full(h_full[g]),
            .head_data(h_data[g]), .req_valid(s_req_v[g]), .req_addr(s_req_a[g])
        );
    end

    sbp_lru #(.NUM(NUM_STREAMS)) u_lru (
        .clk(clk), .rst(rst), .touch(accept), .touch_idx(touch_idx), .victim(victim)
    );

    sbp_req_arb #(.ADDR_W(ADDR_W), .NUM(NUM_STREAMS)) u_arb (
        .dem_valid(state_q == CT_DEM_REQ), .dem_addr(dem_addr_q),
        .s_req_valid(s_req_v), .s_req_addr(s_req_a), .mem_ready(mem_req_ready),
        .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
        .dem_grant(dem_grant), .s_grant(s_grant)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= CT_IDLE;
            dem_addr_q <= '0;
            ret_valid  <= 1'b0;
            ret_addr   <= '0;
            ret_data   <= '0;
        end else begin
            ret_valid <= 1'b0;
            case (state_q)
                CT_IDLE: if (accept) begin
                    if (any_hit) begin
                        ret_valid <= 1'b1;
                        ret_addr  <= miss_addr;
                        ret_data  <= h_data[hit_idx];
                    end else begin
                        dem_addr_q <= miss_addr;
                        state_q    <= CT_DEM_REQ;
                    end
                end
                CT_DEM_REQ: if (dem_grant) state_q <= CT_DEM_WAIT;
                CT_DEM_WAIT: if (dem_done) begin
                    ret_valid <= 1'b1;
                    ret_addr  <= dem_addr_q;
                    ret_data  <= mem_rsp_data;
                    state_q   <= CT_IDLE;
                end
                default: state_q <= CT_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/sbp_checker.sv
module sbp_checker #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              miss_valid,
    input logic              miss_ready,
    input logic [ADDR_W-1:0] miss_addr,
    input logic              ret_valid,
    input logic [ADDR_W-1:0] ret_addr,
    input logic              mem_req_valid,
    input logic [ADDR_W-1:0] mem_req_addr
);
    logic              pend_q;
    logic [ADDR_W-1:0] exp_q;
    logic              acc;

    assign acc = miss_valid && miss_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= 1'b0;
            exp_q  <= '0;
        end else begin
            if (acc) begin
                pend_q <= 1'b1;
                exp_q  <= miss_addr;
            end else if (ret_valid) begin
                pend_q <= 1'b0;
            end
        end
    end

    p_quiet_after_reset_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!ret_valid && !mem_req_valid));

    p_ret_matches_miss_r2: assert property (@(posedge clk) disable iff (rst)
        ret_valid |-> (pend_q && ret_addr == exp_q));

    p_req_addr_known_r3: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid |-> !$isunknown(mem_req_addr));

    p_one_in_flight_r10: assert property (@(posedge clk) disable iff (rst)
        acc |-> (!pend_q || ret_valid));
endmodule

bind sbp_prefetch sbp_checker #(.ADDR_W(ADDR_W)) u_sbp_checker (
    .clk(clk), .rst(rst), .miss_valid(miss_valid), .miss_ready(miss_ready),
    .miss_addr(miss_addr), .ret_valid(ret_valid), .ret_addr(ret_addr),
    .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr)
);

// File: tb/tb_sbp_prefetch.sv
`timescale 1ns/1ps
module tb_sbp_prefetch;
    localparam int AW = 16;
    localparam int DW = 32;
    localparam int LAT = 3;
    localparam int SLOW_LAT = 40;
    localparam logic [AW-1:0] SLOW_ADDR = 16'h0801;
    localparam int NV = 16;

    // {miss address, expect-hit flag, address that must newly be requested}
    localparam logic [47:0] VEC [NV] = '{
        {16'h0100, 16'h0, 16'h0104},  // R2 R3 cold miss
        {16'h0101, 16'h1, 16'h0105},  // R4 R5
        {16'h0102, 16'h1, 16'h0106},
        {16'h0200, 16'h0, 16'h0204},
        {16'h0103, 16'h1, 16'h0107},  // R9 interleaved streams
        {16'h0201, 16'h1, 16'h0205},
        {16'h0300, 16'h0, 16'h0304},
        {16'h0400, 16'h0, 16'h0404},
        {16'h0500, 16'h0, 16'h0504},  // R8 evicts the 0x10x stream
        {16'h0104, 16'h0, 16'h0108},  // R8 evicted head now misses
        {16'h0301, 16'h1, 16'h0305},  // R8 recent stream kept
        {16'h0202, 16'h0, 16'h0206},
        {16'h0105, 16'h1, 16'h0109},
        {16'h0303, 16'h0, 16'h0307},  // R7 younger entry is not compared
        {16'h0302, 16'h1, 16'h0306},
        {16'h0501, 16'h0, 16'h0505}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic miss_valid = 1'b0;
    logic [AW-1:0] miss_addr = '0;
    logic miss_ready, ret_valid, mem_req_valid;
    logic [AW-1:0] ret_addr, mem_req_addr;
    logic [DW-1:0] ret_data;
    logic mem_req_ready = 1'b1;
    logic mem_rsp_valid = 1'b0;
    logic [AW-1:0] mem_rsp_addr = '0;
    logic [DW-1:0] mem_rsp_data = '0;

    int checks = 0;
    int fails = 0;
    int cycle = 0;
    bit done = 0;
    int req_cnt [int];

    logic [AW-1:0] q_addr [16];
    int            q_due  [16];
    bit            q_v    [16];

    always #2.5 clk = ~clk;

    sbp_prefetch dut (
        .clk(clk), .rst(rst), .miss_valid(miss_valid), .miss_addr(miss_addr),
        .miss_ready(miss_ready), .ret_valid(ret_valid), .ret_addr(ret_addr),
        .ret_data(ret_data), .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
        .mem_req_ready(mem_req_ready), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_addr(mem_rsp_addr), .mem_rsp_data(mem_rsp_data)
    );

    function automatic logic [DW-1:0] mem_val(input logic [AW-1:0] a);
        return {a ^ 16'hA5C3, a};
    endfunction

    function automatic int cnt_of(input logic [AW-1:0] a);
        return req_cnt.exists(int'(a)) ? req_cnt[int'(a)] : 0;
    endfunction

    // memory model: out-of-order capable, one response per cycle
    always @(negedge clk) begin
        bit sent;
        sent = 0;
        mem_rsp_valid <= 1'b0;
        for (int i = 0; i < 16; i++) begin
            if (!sent && q_v[i] && q_due[i] <= cycle) begin
                mem_rsp_valid <= 1'b1;
                mem_rsp_addr  <= q_addr[i];
                mem_rsp_data  <= mem_val(q_addr[i]);
                q_v[i] = 0;
                sent = 1;
            end
        end
        if (!rst && mem_req_valid && mem_req_ready) begin
            bit put;
            put = 0;
            req_cnt[int'(mem_req_addr)] = cnt_of(mem_req_addr) + 1;
            for (int i = 0; i < 16; i++) begin
                if (!put && !q_v[i]) begin
                    q_v[i] = 1;
                    q_addr[i] = mem_req_addr;
                    q_due[i] = cycle + ((mem_req_addr == SLOW_ADDR) ? SLOW_LAT : LAT);
                    put = 1;
                end
            end
        end
    end

    always @(posedge clk) begin
        cycle <= cycle + 1;
        if (cycle > 20000 && !done) begin
            done = 1;
            fails++;
            checks++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycle);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic do_miss(input logic [AW-1:0] a, output int lat, output int stall,
                           output logic [AW-1:0] raddr, output logic [DW-1:0] rdata);
        bit acc;
        acc = 0;
        stall = 0;
        lat = 0;
        @(negedge clk);
        miss_valid = 1'b1;
        miss_addr  = a;
        while (!acc) begin
            #1;
            if (miss_ready) acc = 1;
            else begin
                stall++;
                @(negedge clk);
            end
        end
        @(negedge clk);
        miss_valid = 1'b0;
        lat = 1;
        while (!ret_valid && lat < 300) begin
            @(negedge clk);
            lat++;
        end
        raddr = ret_addr;
        rdata = ret_data;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        int lat, stall, before_dem, before_new;
        logic [AW-1:0] ra, a, nreq;
        logic [DW-1:0] rd;
        bit hit;
        for (int i = 0; i < 16; i++) q_v[i] = 0;
        idle(4);
        rst = 1'b0;
        @(negedge clk);
        #1;
        chk(ret_valid == 1'b0, "R1", "ret_valid after reset", ret_valid, 0);
        chk(mem_req_valid == 1'b0, "R1", "mem_req_valid after reset", mem_req_valid, 0);
        chk(miss_ready == 1'b1, "R1", "miss_ready after reset", miss_ready, 1);

        for (int v = 0; v < NV; v++) begin
            a    = VEC[v][47:32];
            hit  = VEC[v][16];
            nreq = VEC[v][15:0];
            before_dem = cnt_of(a);
            before_new = cnt_of(nreq);
            do_miss(a, lat, stall, ra, rd);
            chk(ra == a, "R10", "return address", ra, a);
            chk(rd == mem_val(a), "R2", "return data", rd, mem_val(a));
            if (hit) begin
                chk(lat == 1, "R4", "hit return latency", lat, 1);
            end else begin
                chk(lat > 2, "R7", "unmatched miss goes to memory", lat, 3);
            end
            idle(20);
            if (hit) begin
                chk(cnt_of(a) == before_dem, "R4", "no memory request on hit", cnt_of(a), before_dem);
                chk(cnt_of(nreq) == before_new + 1, "R5", "prefetch after last queued", cnt_of(nreq), before_new + 1);
            end else begin
                chk(cnt_of(a) == before_dem + 1, "R2", "demand request issued", cnt_of(a), before_dem + 1);
                chk(cnt_of(nreq) == before_new + 1, "R3", "stream restart prefetch", cnt_of(nreq), before_new + 1);
                chk(cnt_of(a + 16'd1) >= 1, "R3", "first prefetch of restart", cnt_of(a + 16'd1), 1);
            end
        end

        // R6: oldest entry still waiting on slow memory
        do_miss(16'h0800, lat, stall, ra, rd);
        chk(ra == 16'h0800 && rd == mem_val(16'h0800), "R2", "stall setup return", ra, 16'h0800);
        do_miss(SLOW_ADDR, lat, stall, ra, rd);
        chk(stall > 20, "R6", "held while entry waits", stall, 21);
        chk(lat == 1, "R6", "return after release", lat, 1);
        chk(rd == mem_val(SLOW_ADDR), "R6", "data after stall", rd, mem_val(SLOW_ADDR));
        idle(10);
        chk(cnt_of(SLOW_ADDR) == 1, "R6", "no duplicate request", cnt_of(SLOW_ADDR), 1);

        // R1: reset mid-run clears all streams
        @(negedge clk);
        rst = 1'b1;
        idle(3);
        rst = 1'b0;
        for (int i = 0; i < 16; i++) q_v[i] = 0;
        @(negedge clk);
        #1;
        chk(ret_valid == 1'b0 && mem_req_valid == 1'b0, "R1", "quiet after second reset",
            {ret_valid, mem_req_valid}, 0);
        before_dem = cnt_of(16'h0802);
        do_miss(16'h0802, lat, stall, ra, rd);
        chk(lat > 2, "R1", "streams empty after reset", lat, 3);
        idle(10);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule